// File: doc/BRIEF.md
# Polled Serial Port

A full-duplex asynchronous serial port meant for a small processor that has no interrupt path and learns everything by polling. Software writes bytes into a one-deep transmit holding register, reads received bytes from a receive buffer register, and polls a status register for data-ready, transmit-holding-empty, transmitter-empty and three receive error flags together with their summary. Reading the receive buffer or the status word has side effects that the status bits depend on.

Both directions share one programmable baud divisor. It produces a tick at sixteen times the bit rate. Each character is a start bit, eight data bits sent least significant bit first, an even parity bit and a stop bit. The transmitter is double-buffered, so a byte written while another is shifting follows it with no idle time on the line. The receiver oversamples the line, confirms a start bit at its middle and samples every later bit at its centre.

Top module: `sio_poll`

## Requirements
- R1: After reset the status word reads 0x0006, the receive buffer reads 0 and the divisor register reads the parameter RST_DIV. Register selects: 0 transmit buffer (write), 1 receive buffer (read), 2 status (read), 3 baud divisor (read and write).
- R2: The 16x tick fires once every D system clocks, where D is the divisor register value (0 behaves as 1). A divisor write restarts the count. Every serial bit lasts exactly 16 ticks.
- R3: The transmit line idles high. A frame is a low start bit, data bits 0 through 7, a parity bit that makes the count of ones in data plus parity even, and a high stop bit.
- R4: Status bit 1 (transmit holding empty) goes to 1 on the clock in which the held byte moves into the shifter and goes to 0 on a transmit buffer write. A byte waiting in the holding register starts its start bit on the clock right after the previous stop bit. A write while the holding register is full replaces the waiting byte.
- R5: Status bit 2 is 1 exactly when neither the holding register nor the shifter holds a byte.
- R6: A low level on the receive line that lasts less than half a bit time is not taken as a start bit and produces no character.
- R7: Status bit 0 (data-ready) becomes 1 when a character is accepted. The receive buffer read returns the byte in bits 7:0 with all upper bits zero, and that read clears data-ready.
- R8: Status bit 4 (parity error) is set when the received parity bit makes the ones count odd; status bit 5 (framing error) is set when the stop bit is sampled low. Both describe the last accepted character.
- R9: Status bit 6 (overrun) is set when a character completes while data-ready is 1; that character is discarded and the receive buffer keeps the older byte. Overrun stays set until a status read, which clears it.
- R10: Status bit 7 is the OR of bits 6, 5 and 4; bit 3 and bits above 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select for reads and writes |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; applies read side effects at the clock edge |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data of the selected register, valid in the same cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bench builds the port with RST_DIV set to 2, so a frame takes 352 clocks and every receive case, a double-buffered transmit burst and a replaced holding byte all fit in a short run. It then rewrites the divisor to 3, 1 and 0 at run time. The last two bring the degenerate every-clock tick within reach, where the synchroniser delay is a large part of a tick and the mid-bit sampling margin is smallest. SYNC_STAGES stays at its default of 2.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int OVS        = 16;
  localparam int FRAME_BITS = 11;
  localparam int BYTE_W     = 8;

  // status bit positions
  localparam int ST_DR  = 0;
  localparam int ST_THE = 1;
  localparam int ST_TXE = 2;
  localparam int ST_PE  = 4;
  localparam int ST_FE  = 5;
  localparam int ST_OE  = 6;
  localparam int ST_RE  = 7;

  typedef enum logic [1:0] {
    SEL_TX   = 2'd0,
    SEL_RX   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_BAUD = 2'd3
  } sel_e;

  function automatic logic even_par(input logic [BYTE_W-1:0] d);
    return ^d;
  endfunction

  // bit 0 leaves first: start, data LSB..MSB, parity, stop
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [BYTE_W-1:0] d);
    return {1'b1, even_par(d), d, 1'b0};
  endfunction

  function automatic logic [7:0] pack_status(
    input logic dr, input logic the, input logic txe,
    input logic pe, input logic fe, input logic oe);
    logic [7:0] s;
    s         = '0;
    s[ST_DR]  = dr;
    s[ST_THE] = the;
    s[ST_TXE] = txe;
    s[ST_PE]  = pe;
    s[ST_FE]  = fe;
    s[ST_OE]  = oe;
    s[ST_RE]  = pe | fe | oe;
    return s;
  endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W   = 16,
  parameter int RST_DIV = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wval,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;

  assign last_cnt = (div_q == '0) ? '0 : div_q - 1'b1;
  assign tick     = (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(RST_DIV);
      cnt_q <= '0;
    end else if (div_we) begin
      div_q <= div_wval;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_idle,
  output logic              load
);

  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [BYTE_W-1:0]     hold_q;
  logic                  hold_full_q;
  logic                  busy_q;
  logic [SUB_W-1:0]      sub_q;
  logic [BIT_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] shf_q;
  logic                  bit_end;
  logic                  frame_end;

  assign bit_end   = busy_q && (sub_q == SUB_LAST);
  assign frame_end = bit_end && (bit_q == BIT_LAST);
  assign load      = tick && hold_full_q && (!busy_q || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sub_q  <= '0;
      bit_q  <= '0;
      shf_q  <= '1;
    end else if (tick) begin
      if (load) begin
        busy_q <= 1'b1;
        sub_q  <= '0;
        bit_q  <= '0;
        shf_q  <= build_frame(hold_q);
      end else if (busy_q) begin
        if (bit_end) begin
          sub_q <= '0;
          shf_q <= {1'b1, shf_q[FRAME_BITS-1:1]};
          if (frame_end) begin
            busy_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else begin
      if (wr) begin
        hold_full_q <= 1'b1;
        hold_q      <= wbyte;
      end else if (load) begin
        hold_full_q <= 1'b0;
      end
    end
  end

  assign txd        = busy_q ? shf_q[0] : 1'b1;
  assign hold_empty = !hold_full_q;
  assign tx_idle    = !busy_q && !hold_full_q;

endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic [BYTE_W-1:0] dbyte,
  output logic              perr,
  output logic              ferr
);

  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] MID_LAST = SUB_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_e              state_q;
  logic [SUB_W-1:0]       cnt_q;
  logic [IDX_W-1:0]       idx_q;
  logic [BYTE_W-1:0]      sh_q;
  logic                   par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  assign rx_s  = sync_q[SYNC_STAGES-1];
  assign dbyte = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      done    <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rx_s) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == MID_LAST) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == SUB_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_s, sh_q[BYTE_W-1:1]};
              if (idx_q == IDX_LAST) state_q <= RX_PAR;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt_q == SUB_LAST) begin
              cnt_q   <= '0;
              par_q   <= rx_s;
              state_q <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == SUB_LAST) begin
              cnt_q   <= '0;
              done    <= 1'b1;
              ferr    <= !rx_s;
              perr    <= even_par(sh_q) ^ par_q;
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sio_poll.sv
module sio_poll
  import sio_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int DIV_W       = 16,
  parameter int RST_DIV     = 27,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             rxd,
  output logic             txd
);

  sel_e              sel;
  logic              wr_tx, wr_div, rd_rx, rd_st;
  logic              baud_tick;
  logic [DIV_W-1:0]  div_q;
  logic              tx_load, tx_hold_empty, tx_idle;
  logic              rx_done, rx_perr, rx_ferr;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] rx_data_q;
  logic              dr_q, pe_q, fe_q, oe_q;
  logic              ovr_evt, rx_accept;
  logic [7:0]        status_b;

  assign sel    = sel_e'(reg_sel);
  assign wr_tx  = wr_en && (sel == SEL_TX);
  assign wr_div = wr_en && (sel == SEL_BAUD);
  assign rd_rx  = rd_en && (sel == SEL_RX);
  assign rd_st  = rd_en && (sel == SEL_STAT);

  sio_baud #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_we(wr_div),
    .div_wval(wdata[DIV_W-1:0]), .div_q(div_q), .tick(baud_tick)
  );

  sio_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .wr(wr_tx),
    .wbyte(wdata[BYTE_W-1:0]), .txd(txd), .hold_empty(tx_hold_empty),
    .tx_idle(tx_idle), .load(tx_load)
  );

  sio_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
    .done(rx_done), .dbyte(rx_byte), .perr(rx_perr), .ferr(rx_ferr)
  );

  // a read in the completing cycle frees the buffer first
  assign ovr_evt   = rx_done && dr_q && !rd_rx;
  assign rx_accept = rx_done && !ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q <= '0;
      dr_q      <= 1'b0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
    end else if (rx_accept) begin
      rx_data_q <= rx_byte;
      dr_q      <= 1'b1;
      pe_q      <= rx_perr;
      fe_q      <= rx_ferr;
    end else if (rd_rx) begin
      dr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oe_q <= 1'b0;
    else if (ovr_evt) oe_q <= 1'b1;
    else if (rd_st)   oe_q <= 1'b0;
  end

  assign status_b = pack_status(dr_q, tx_hold_empty, tx_idle, pe_q, fe_q, oe_q);

  always_comb begin
    unique case (sel)
      SEL_RX:   rdata = REG_W'(rx_data_q);
      SEL_STAT: rdata = REG_W'(status_b);
      SEL_BAUD: rdata = REG_W'(div_q);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/sio_poll_chk.sv
module sio_poll_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       tx_load,
  input logic       tx_idle,
  input logic       txd,
  input logic       wr_tx,
  input logic       rd_rx,
  input logic       rd_st,
  input logic       rx_done,
  input logic       ovr_evt,
  input logic [7:0] status,
  input logic [7:0] rx_data
);

  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tick); // R2
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd); // R3
  AST_THE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !wr_tx) |=> status[1]); // R4
  AST_DR_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_done) |=> !status[0]); // R7
  AST_DR_RISES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(rx_done)); // R7
  AST_OVR_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(rx_data)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !rd_st) |=> status[6]); // R9

endmodule

bind sio_poll sio_poll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_load(tx_load),
  .tx_idle(tx_idle), .txd(txd), .wr_tx(wr_tx), .rd_rx(rd_rx),
  .rd_st(rd_st), .rx_done(rx_done), .ovr_evt(ovr_evt),
  .status(status_b), .rx_data(rx_data_q)
);

// File: tb/sio_poll_bench.sv
module sio_poll_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BENCH_DIV  = 2;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd2;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rxd = 1'b1;
  logic        txd;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit cmp_on = 0;

  sio_poll #(.RST_DIV(BENCH_DIV)) u_sio_poll (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int         m_div, m_cnt, m_sub;
  bit         m_hfull;
  logic [7:0] m_hold;
  bit         m_q[$];
  bit         m_tick;
  bit         m_dr, m_pe, m_fe, m_oe;
  logic [7:0] m_data;

  function automatic int eff_div();
    return (m_div == 0) ? 1 : m_div;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = BENCH_DIV; m_cnt = 0; m_sub = 0; m_hfull = 0; m_hold = 0;
      m_q.delete();
    end else begin
      m_tick = (m_cnt == eff_div() - 1);
      if (m_tick) begin
        if (m_q.size() != 0) begin
          m_sub++;
          if (m_sub == 16) begin
            m_sub = 0;
            void'(m_q.pop_front());
          end
        end
        if (m_q.size() == 0 && m_hfull) begin
          m_q.push_back(1'b0);
          for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
          m_q.push_back(^m_hold);
          m_q.push_back(1'b1);
          m_sub = 0;
          m_hfull = 0;
        end
      end
      if (wr_en && reg_sel == 2'd0) begin
        m_hfull = 1; m_hold = wdata[7:0];
      end
      if (wr_en && reg_sel == 2'd3) begin
        m_div = int'(wdata); m_cnt = 0;
      end else if (m_tick) m_cnt = 0;
      else m_cnt++;
    end
  end

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = '0;
    s[0] = m_dr;
    s[1] = !m_hfull;
    s[2] = (m_q.size() == 0) && !m_hfull;
    s[4] = m_pe; s[5] = m_fe; s[6] = m_oe;
    s[7] = m_pe | m_fe | m_oe;
    return s;
  endfunction

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every clock: line and transmit status against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R3 txd vs model", {15'b0, txd}, {15'b0, (m_q.size() != 0) ? m_q[0] : 1'b1});
      if (reg_sel == 2'd2 && !rd_en) begin
        check("R4 holding-empty bit", {15'b0, rdata[1]}, {15'b0, !m_hfull});
        check("R5 transmitter-empty bit", {15'b0, rdata[2]},
              {15'b0, (m_q.size() == 0) && !m_hfull});
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d cycles expected=below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [15:0] val);
    step(); reg_sel = sel; wdata = val; wr_en = 1'b1;
    step(); wr_en = 1'b0; reg_sel = 2'd2;
  endtask

  task automatic read_reg(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    step(); reg_sel = sel; rd_en = 1'b1; #1;
    check(tag, rdata, exp);
    step();
    if (sel == 2'd1) m_dr = 0;
    rd_en = 1'b0; reg_sel = 2'd2;
  endtask

  task automatic read_status(input string tag);
    step(); reg_sel = 2'd2; rd_en = 1'b1; #1;
    check(tag, rdata, exp_status());
    check({"R10 summary and zero bits, ", tag}, {rdata[15:8], rdata[7], rdata[3]},
          {8'h00, m_pe | m_fe | m_oe, 1'b0});
    step();
    m_oe = 0;
    rd_en = 1'b0;
  endtask

  task automatic wait_tx_idle();
    while (!((m_q.size() == 0) && !m_hfull)) step();
    repeat (4) step();
  endtask

  task automatic send_rx(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic [10:0] fr;
    int bt;
    bt = 16 * eff_div();
    fr = {!bad_stop, (^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = fr[i];
      repeat (bt) step();
    end
    rxd = 1'b1;
    if (m_dr) m_oe = 1;
    else begin
      m_dr = 1; m_data = b; m_pe = bad_par; m_fe = bad_stop;
    end
    repeat (2 * bt) step();
  endtask

  // ---------------- test sequence ----------------
  initial begin
    logic pv;
    int   n;
    m_dr = 0; m_pe = 0; m_fe = 0; m_oe = 0; m_data = 0;
    repeat (4) step();
    rst_n = 1'b1;
    cmp_on = 1;
    step();

    // R1 reset values
    read_reg(2'd2, 16'h0006, "R1 status after reset");
    read_reg(2'd1, 16'h0000, "R1 receive buffer after reset");
    read_reg(2'd3, 16'(BENCH_DIV), "R1 divisor after reset");

    // R2 bit length at the reset divisor
    write_reg(2'd0, 16'h0001);
    while (txd !== 1'b0) step();
    n = 0;
    while (txd === 1'b0) begin n++; step(); end
    check("R2 start bit length in clocks", 16'(n), 16'(16 * BENCH_DIV));
    wait_tx_idle();

    // R4 double buffering, replacement of a waiting byte, no gap
    write_reg(2'd0, 16'h00A5);
    while (rdata[1] !== 1'b1) step();
    write_reg(2'd0, 16'h003C);
    write_reg(2'd0, 16'h00C3);
    read_status("R4 holding full while shifting");
    pv = txd;
    step();
    while (rdata[1] !== 1'b1) begin pv = txd; step(); end
    check("R4 clock before reload carries stop bit", {15'b0, pv}, 16'h0001);
    check("R4 next start bit follows at once", {15'b0, txd}, 16'h0000);
    wait_tx_idle();
    read_status("R5 status after transmit drains");

    // R2 other divisors, including 0 treated as 1
    write_reg(2'd3, 16'd3);
    read_reg(2'd3, 16'd3, "R2 divisor readback");
    write_reg(2'd0, 16'h005A);
    wait_tx_idle();
    write_reg(2'd3, 16'd0);
    write_reg(2'd0, 16'h0081);
    while (txd !== 1'b0) step();
    n = 0;
    while (txd === 1'b0) begin n++; step(); end
    check("R2 divisor zero behaves as one", 16'(n), 16'd16);
    wait_tx_idle();
    write_reg(2'd3, 16'd1);
    write_reg(2'd0, 16'h007E);
    wait_tx_idle();

    // receive at divisor 1
    send_rx(8'h4B, 0, 0);
    read_status("R7 data ready at divisor one");
    read_reg(2'd1, 16'h004B, "R7 byte at divisor one");
    write_reg(2'd3, 16'(BENCH_DIV));

    // R7 good character
    send_rx(8'h96, 0, 0);
    read_status("R7 data ready set");
    read_reg(2'd1, 16'h0096, "R7 received byte, upper bits zero");
    read_status("R7 data ready cleared by buffer read");

    // R8 parity error
    send_rx(8'h5C, 1, 0);
    read_status("R8 parity error flagged");
    read_reg(2'd1, 16'h005C, "R8 byte with parity error");

    // R8 framing error
    send_rx(8'h3F, 0, 1);
    read_status("R8 framing error flagged");
    read_reg(2'd1, 16'h003F, "R8 byte with framing error");
    send_rx(8'h21, 0, 0);
    read_status("R8 flags follow the newer character");
    read_reg(2'd1, 16'h0021, "R8 clean byte");

    // R6 short low pulse ignored
    rxd = 1'b0;
    repeat (4 * BENCH_DIV) step();
    rxd = 1'b1;
    repeat (40 * BENCH_DIV) step();
    read_status("R6 no character from a short pulse");
    read_reg(2'd1, 16'h0021, "R6 receive buffer unchanged");

    // R9 overrun
    send_rx(8'h11, 0, 0);
    send_rx(8'h22, 0, 0);
    read_status("R9 overrun set, data ready kept");
    read_status("R9 overrun cleared by status read");
    read_reg(2'd1, 16'h0011, "R9 older byte kept, newer discarded");
    read_status("R9 status after recovery");

    // full duplex: transmit while receiving
    write_reg(2'd0, 16'h00E7);
    send_rx(8'h69, 0, 0);
    wait_tx_idle();
    read_status("R7 receive during transmit");
    read_reg(2'd1, 16'h0069, "R7 byte received during transmit");

    repeat (10) step();
    finish_run();
  end

endmodule